// File: doc/BRIEF.md
# Triplicated 30-Bit Parallel Payload Scrambler

This block whitens frame payload words before serialization. Each cycle it can take one 30-bit word and return its scrambled form one clock later. The scrambling is self-synchronous with polynomial x^58 + x^39 + 1: every scrambled bit is the input bit XORed with the scrambled bits sent 39 and 58 positions earlier. Within a word, bit 0 is the earliest in time. All 30 bits of a word are computed in parallel from a 58-bit history of past scrambled bits. The result is a DC-balanced stream with no line-code overhead, made only of XOR gates. A receiver recovers the payload with the mirror equation and no handshake, once 58 bits have passed.

The history has no reset, so only the feedback loop can clear a corrupted state. For that reason it is kept in three copies. Every copy's flop loads a bitwise majority of the three copies. An upset in one copy never reaches the output, and the copy is rewritten with the voted value on the next clock, whether or not a word is accepted on that edge.

Top module: `scr_tmr_parallel`

## Requirements
- R1: For the stream of accepted words, taken in order with bit 0 of each word first, every output bit s[n] equals d[n] XOR s[n-39] XOR s[n-58], where d is the input stream and s the output stream.
- R2: A word presented with valid_i high appears on data_o, with valid_o high, after the next rising clock edge. Words may be presented on every cycle back to back.
- R3: A cycle with valid_i low leaves the history unchanged, keeps data_o at its last value and drives valid_o low. The data_i value on that cycle has no effect, and the R1 relation continues across the gap.
- R4: While rst_ni is low, valid_o and data_o are zero. The history is not cleared, so the R1 relation holds for the first word after reset, computed from words sent before it.
- R5: The history is held in three copies, and each copy's flop loads the bitwise majority of the copies. A corrupted single copy does not change data_o and is repaired on the next clock edge.
- R6: Descrambling the output with d[n] = s[n] XOR s[n-39] XOR s[n-58] restores the input for every n from 58 on, whatever the history held at power-up.
- R7: One flipped bit at position p in the scrambled stream gives exactly three errors after descrambling, at positions p, p+39 and p+58.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register only |
| valid_i | input | 1 | Accept data_i and advance the history this cycle |
| data_i | input | 30 | Payload word, bit 0 earliest |
| valid_o | output | 1 | data_o carries a newly scrambled word |
| data_o | output | 30 | Scrambled word, bit 0 earliest |

## Verification
On every cycle, the assertions check the one-cycle output timing, the holding of data_o and of the voted history on idle cycles, the cleared outputs during reset, and that the voter follows any two agreeing copies. The stream relation across word boundaries, idle gaps and a mid-stream reset can only be shown by the bench's scenarios. The same holds for descrambler convergence from an unknown power-up state, the threefold error multiplication, and masking and repair after a copy is overwritten from outside. These need the bench's record of many past output bits.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int SCR_WORD_W = 30;
  localparam int SCR_DEG    = 58;
  localparam int SCR_TAP    = 39;
  localparam int SCR_COPIES = 3;
endpackage

// File: rtl/scr_maj3.sv
module scr_maj3 #(
  parameter int W = 58
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/scr_copy_reg.sv
module scr_copy_reg #(
  parameter int W = 58
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // no reset: only the voted feedback can clear an upset
  always_ff @(posedge clk_i) q_q <= d_i;

  assign q_o = q_q;
endmodule

// File: rtl/scr_tmr_state.sv
module scr_tmr_state #(
  parameter int W = scr_pkg::SCR_DEG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] vote_o
);
  localparam int NCOPY = scr_pkg::SCR_COPIES;

  logic [W-1:0] load;
  logic [W-1:0] cp [NCOPY];

  // every copy loads from the voted value, so a lone upset is overwritten
  assign load = en_i ? nxt_i : vote_o;

  for (genvar g = 0; g < NCOPY; g++) begin : gen_copy
    scr_copy_reg #(.W(W)) u_reg (
      .clk_i (clk_i),
      .d_i   (load),
      .q_o   (cp[g])
    );
  end

  scr_maj3 #(.W(W)) u_vote (
    .a_i (cp[0]),
    .b_i (cp[1]),
    .c_i (cp[2]),
    .y_o (vote_o)
  );

  a_r5_mask_ab: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp[0] == cp[1]) |-> (vote_o == cp[0]));
  a_r5_mask_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp[0] == cp[2]) |-> (vote_o == cp[0]));
  a_r5_mask_bc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp[1] == cp[2]) |-> (vote_o == cp[1]));
  a_r3_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && cp[0] == cp[1] && cp[1] == cp[2]) |=> $stable(vote_o));
endmodule

// File: rtl/scr_mix.sv
module scr_mix #(
  parameter int W   = scr_pkg::SCR_WORD_W,
  parameter int DEG = scr_pkg::SCR_DEG,
  parameter int TAP = scr_pkg::SCR_TAP
) (
  input  logic [DEG-1:0] hist_i,   // bit k: scrambled bit k+1 steps back
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   scr_o,
  output logic [DEG-1:0] hist_nxt_o
);
  for (genvar i = 0; i < W; i++) begin : gen_bit
    logic ta, tb;
    if (i >= TAP) begin : gen_a_word
      assign ta = scr_o[i-TAP];
    end else begin : gen_a_hist
      assign ta = hist_i[TAP-1-i];
    end
    if (i >= DEG) begin : gen_b_word
      assign tb = scr_o[i-DEG];
    end else begin : gen_b_hist
      assign tb = hist_i[DEG-1-i];
    end
    assign scr_o[i] = data_i[i] ^ ta ^ tb;
  end

  for (genvar k = 0; k < DEG; k++) begin : gen_shift
    if (k < W) begin : gen_new
      assign hist_nxt_o[k] = scr_o[W-1-k];
    end else begin : gen_old
      assign hist_nxt_o[k] = hist_i[k-W];
    end
  end
endmodule

// File: rtl/scr_tmr_parallel.sv
module scr_tmr_parallel #(
  parameter int W   = scr_pkg::SCR_WORD_W,
  parameter int DEG = scr_pkg::SCR_DEG,
  parameter int TAP = scr_pkg::SCR_TAP
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [DEG-1:0] hist_v, hist_n;
  logic [W-1:0]   scr;

  scr_tmr_state #(.W(DEG)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .nxt_i  (hist_n),
    .vote_o (hist_v)
  );

  scr_mix #(.W(W), .DEG(DEG), .TAP(TAP)) u_mix (
    .hist_i     (hist_v),
    .data_i     (data_i),
    .scr_o      (scr),
    .hist_nxt_o (hist_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= scr;
    end
  end

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));
  a_r3_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(valid_i)) |-> $stable(data_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r4_reset_clear: assert (!valid_o && data_o == '0);
    end
  end
endmodule

// File: tb/sim_scr_tmr_parallel.sv
module sim_scr_tmr_parallel;
  localparam int W   = 30;
  localparam int DEG = 58;
  localparam int TAP = 39;
  localparam logic [DEG-1:0] INJ = 58'h2AAAAAAAAAAAAAA;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_o;
  logic [W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int nb = 0;
  bit done = 1'b0;
  logic sb [0:8191];
  logic db [0:8191];
  logic [W-1:0] last_out = '0;
  logic [31:0] lf = 32'h1234_5678;

  scr_tmr_parallel u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    lf = lf * 32'd1103515245 + 32'd12345;
    return lf[31:2];
  endfunction

  task automatic word(input logic v, input logic [W-1:0] d, input string tag);
    logic [W-1:0] expw;
    logic [W-1:0] mask;
    @(negedge clk);
    valid_i = v;
    data_i  = d;
    @(posedge clk);
    #1;
    if (v) begin
      chk(valid_o === 1'b1, "R2", "valid_o after accepted word", 64'(valid_o), 64'd1);
      expw = '0;
      mask = '0;
      for (int i = 0; i < W; i++) begin
        int idx;
        idx = nb + i;
        sb[idx] = data_o[i];
        db[idx] = d[i];
        if (idx >= DEG) begin
          mask[i] = 1'b1;
          expw[i] = d[i] ^ sb[idx-TAP] ^ sb[idx-DEG];
        end
      end
      nb += W;
      last_out = data_o;
      if (mask != '0)
        chk(((data_o ^ expw) & mask) == '0, tag, "scrambled word",
            64'(data_o & mask), 64'(expw & mask));
    end else begin
      chk(valid_o === 1'b0 && data_o === last_out, "R3", "idle cycle hold",
          64'({valid_o, data_o}), 64'({1'b0, last_out}));
    end
  endtask

  // overwrite one history copy between clock edges
  task automatic inject(input int g);
    #1;
    case (g)
      0: force u0.u_state.gen_copy[0].u_reg.q_q = INJ;
      1: force u0.u_state.gen_copy[1].u_reg.q_q = INJ;
      default: force u0.u_state.gen_copy[2].u_reg.q_q = INJ;
    endcase
    #1;
    case (g)
      0: release u0.u_state.gen_copy[0].u_reg.q_q;
      1: release u0.u_state.gen_copy[1].u_reg.q_q;
      default: release u0.u_state.gen_copy[2].u_reg.q_q;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    int diffs;
    int badpos;
    int mism;
    repeat (3) @(posedge clk);
    #1;
    chk(valid_o === 1'b0 && data_o === '0, "R4", "outputs in reset",
        64'({valid_o, data_o}), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int k = 0; k < 20; k++) word(1'b1, '0, "R1");
    for (int k = 0; k < 20; k++) word(1'b1, '1, "R1");
    for (int k = 0; k < 3; k++)  word(1'b0, rnd(), "R3");
    for (int k = 0; k < 20; k++) word(1'b1, 30'h2AAAAAAA, "R3");

    // single-copy upsets, each repaired before the next
    inject(1);
    word(1'b1, rnd(), "R5");
    word(1'b1, rnd(), "R5");
    inject(2);
    word(1'b1, rnd(), "R5");
    inject(0);
    word(1'b0, rnd(), "R3");
    word(1'b1, rnd(), "R5");
    inject(1);
    word(1'b1, rnd(), "R5");

    // mid-stream reset keeps the history
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    @(posedge clk);
    #1;
    chk(valid_o === 1'b0 && data_o === '0, "R4", "outputs cleared by reset",
        64'({valid_o, data_o}), 64'd0);
    last_out = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 20; k++) word(1'b1, W'(k * 7 + 1), "R4");

    for (int k = 0; k < 20; k++) begin
      word(1'b1, W'(1) << (k % W), "R1");
      word(1'b0, rnd(), "R3");
    end
    for (int k = 0; k < 30; k++) word(1'b1, rnd(), "R1");

    mism = 0;
    for (int n = DEG; n < nb; n++)
      if ((sb[n] ^ sb[n-TAP] ^ sb[n-DEG]) !== db[n]) mism++;
    chk(mism == 0, "R6", "descrambled mismatches", 64'(mism), 64'd0);

    p = 300;
    diffs = 0;
    badpos = 0;
    for (int n = p; n < p + 80; n++) begin
      logic o, f;
      o = sb[n] ^ sb[n-TAP] ^ sb[n-DEG];
      f = (sb[n] ^ (n == p)) ^ (sb[n-TAP] ^ (n - TAP == p)) ^ (sb[n-DEG] ^ (n - DEG == p));
      if (o != f) begin
        diffs++;
        if (!(n == p || n == p + TAP || n == p + DEG)) badpos++;
      end
    end
    chk(diffs == 3, "R7", "error count after one line flip", 64'(diffs), 64'd3);
    chk(badpos == 0, "R7", "errors outside p, p+39, p+58", 64'(badpos), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule